// File: doc/BRIEF.md
# Cascaded Card Selection Sequencer

This controller runs the selection procedure that isolates one proximity card and reads its full identifier. It works through up to three cascade levels. At each level it first sends an anticollision frame that carries the identifier bits already known. When all 32 bits of the level are known, it sends a full select frame that ends in a check byte and a CRC_A. Each frame goes out on an abstract transceive port, which is a request pulse with the frame bytes and bit-framing counts. A later reply returns a status, the received bytes, a last-byte bit count and a collision position.

When two cards answer at once, the sequencer merges the bits received up to the collision point. It then forces the colliding bit to 1 and retries with the longer known prefix. After each select it checks the shape and CRC of the one-byte acknowledge, and that byte decides whether another cascade level follows. At the end the sequencer presents a 4, 7 or 10 byte identifier, the final acknowledge byte and a status code. A single-cycle done pulse marks completion.

Top module: `csel_seq`

## Requirements
- R1: Every frame starts with the level command byte: 0x93 at level 1, 0x95 at level 2 and 0x97 at level 3.
- R2: An anticollision frame with k known bits (k < 32) has byte 1 = ((2 + k/8) << 4) | (k mod 8). Its length is 2 + k/8 bytes, plus one more byte when k mod 8 is not 0. The last-byte bit count and the receive alignment both equal k mod 8. The first frame of each level is therefore cmd, 0x20 with length 2.
- R3: A select frame is 9 bytes: cmd, 0x70, four data bytes, the XOR of those four, then the CRC_A of bytes 0..6 with the low byte first. CRC_A is reflected x^16+x^12+x^5+1 with preset 0x6363. The last-byte bit count is 0.
- R4: On a reply with status 2 (collision), the received bytes are merged at byte k/8. The low k mod 8 bits of that first byte keep their known values. A reported position of 0 means 32. The bit at the position p is set to 1, with bit 1 being bit 0 of data byte 0. The known count becomes p and a new frame is sent.
- R5: A collision whose position is flagged invalid, or whose position is not above the known count, ends the run with status 2.
- R6: A select reply must hold 3 bytes with last-bit count 0, or the run ends with status 4. Its bytes 1..2 must equal the CRC_A of byte 0, low byte first, or the run ends with status 3.
- R7: An acknowledge with bit 2 set starts the next level. A level whose data byte 0 is 0x88 (levels 1 and 2) gives 3 identifier bytes, taken from data bytes 1..3. At level 3 such an acknowledge ends the run with status 4.
- R8: On success the status is 0, the identifier length is 3 × level + 1, and the identifier is packed with byte i at bits 8i+7..8i. The acknowledge byte is also output.
- R9: A reply with status 1 (timeout) ends the run with status 1. A reply with status 3 (error) ends it with status 4.
- R10: After reset, done, busy and the request are 0. Done is high for exactly one cycle per run. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a selection run (ignored while busy) |
| txn_req | output | 1 | One-cycle request to transmit the frame |
| txn_frame | output | 72 | Frame bytes, byte i at bits 8i+7..8i |
| txn_len | output | 4 | Number of frame bytes to send |
| txn_last_bits | output | 3 | Valid bits in last sent byte (0 = all 8) |
| txn_rx_align | output | 3 | Bit position of first received bit |
| rsp_valid | input | 1 | Reply present this cycle |
| rsp_status | input | 2 | 0 ok, 1 timeout, 2 collision, 3 error |
| rsp_len | input | 3 | Number of valid reply bytes (0..4) |
| rsp_last_bits | input | 3 | Valid bits in last reply byte (0 = all 8) |
| rsp_data | input | 32 | Reply bytes without the trailing check byte |
| rsp_coll_pos | input | 5 | Collision bit position, 0 meaning 32 |
| rsp_coll_invalid | input | 1 | Collision position not usable |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 timeout, 2 collision abort, 3 CRC error, 4 protocol error |
| uid | output | 80 | Identifier bytes, byte i at bits 8i+7..8i |
| uid_len | output | 4 | Identifier length in bytes |
| sak | output | 8 | Final acknowledge byte |

## Verification
A frame request rises in the cycle after the clock edge that accepts start or a reply. Done, status, identifier and acknowledge become valid in the cycle after the edge that takes the final reply. The bench drives every input on a falling edge and holds a reply for exactly one cycle. It then samples on the following falling edge, which is the first point where either the next request or the done pulse is due. It samples once more a cycle later to confirm that done has dropped.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int LEVELS      = 3;
  localparam int FRAME_BYTES = 9;
  localparam int DATA_BYTES  = 4;
  localparam int UID_BYTES   = 10;
  localparam int LEVEL_BITS  = 32;
  localparam int KNOWN_W     = $clog2(LEVEL_BITS + 1);

  localparam logic [7:0]  CASCADE_TAG  = 8'h88;
  localparam logic [15:0] CRC_PRESET   = 16'h6363;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [7:0]  FULL_NVB     = 8'h70;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_TIMEOUT = 3'd1,
    ST_COLL    = 3'd2,
    ST_CRC     = 3'd3,
    ST_PROTO   = 3'd4
  } sel_status_e;

  typedef enum logic [1:0] {
    RSP_OK      = 2'd0,
    RSP_TIMEOUT = 2'd1,
    RSP_COLL    = 2'd2,
    RSP_ERR     = 2'd3
  } rsp_kind_e;

  // One byte through the reflected CRC_A register, bit by bit
  function automatic logic [15:0] crc_a_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REV;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Level command: 0x93, 0x95, 0x97
  function automatic logic [7:0] sel_cmd(input logic [1:0] level);
    return 8'h91 + {5'd0, level, 1'b0};
  endfunction

  // Valid-bit count byte for a frame carrying 'known' level bits
  function automatic logic [7:0] nvb_of(input logic [KNOWN_W-1:0] known);
    if (known >= KNOWN_W'(LEVEL_BITS)) return FULL_NVB;
    return {4'd2 + {2'd0, known[4:3]}, 1'b0, known[2:0]};
  endfunction

  function automatic logic [7:0] bcc_of(input logic [8*DATA_BYTES-1:0] d);
    logic [7:0] x;
    x = '0;
    for (int i = 0; i < DATA_BYTES; i++) x = x ^ d[8*i +: 8];
    return x;
  endfunction
endpackage

// File: rtl/csel_frame_build.sv
module csel_frame_build
  import csel_pkg::*;
(
  input  logic [1:0]               level,
  input  logic [KNOWN_W-1:0]       known,
  input  logic [8*DATA_BYTES-1:0]  dat,
  output logic [8*FRAME_BYTES-1:0] frame,
  output logic [3:0]               len,
  output logic [2:0]               last_bits,
  output logic                     is_select
);
  localparam int CRC_SPAN = FRAME_BYTES - 2;

  logic [15:0] crc;

  always_comb begin
    is_select = (known >= KNOWN_W'(LEVEL_BITS));
    frame     = '0;
    frame[7:0]  = sel_cmd(level);
    frame[15:8] = nvb_of(known);
    frame[16 +: 8*DATA_BYTES] = dat;
    crc = CRC_PRESET;
    if (is_select) begin
      frame[8*(2+DATA_BYTES) +: 8] = bcc_of(dat);
      for (int i = 0; i < CRC_SPAN; i++) crc = crc_a_step(crc, frame[8*i +: 8]);
      frame[8*CRC_SPAN +: 8]     = crc[7:0];
      frame[8*(CRC_SPAN+1) +: 8] = crc[15:8];
      len       = 4'(FRAME_BYTES);
      last_bits = 3'd0;
    end else begin
      len       = 4'd2 + {2'd0, known[4:3]} + {3'd0, (known[2:0] != 3'd0)};
      last_bits = known[2:0];
    end
  end
endmodule

// File: rtl/csel_ack_check.sv
module csel_ack_check
  import csel_pkg::*;
(
  input  logic [23:0] ack,
  output logic        crc_ok
);
  logic [15:0] crc;
  always_comb begin
    crc    = crc_a_step(CRC_PRESET, ack[7:0]);
    crc_ok = (ack[15:8] == crc[7:0]) && (ack[23:16] == crc[15:8]);
  end
endmodule

// File: rtl/csel_seq.sv
module csel_seq
  import csel_pkg::*;
#(
  parameter int MAX_LEVEL = LEVELS
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     txn_req,
  output logic [8*FRAME_BYTES-1:0] txn_frame,
  output logic [3:0]               txn_len,
  output logic [2:0]               txn_last_bits,
  output logic [2:0]               txn_rx_align,
  input  logic                     rsp_valid,
  input  logic [1:0]               rsp_status,
  input  logic [2:0]               rsp_len,
  input  logic [2:0]               rsp_last_bits,
  input  logic [8*DATA_BYTES-1:0]  rsp_data,
  input  logic [4:0]               rsp_coll_pos,
  input  logic                     rsp_coll_invalid,
  output logic                     busy,
  output logic                     done,
  output logic [2:0]               status,
  output logic [8*UID_BYTES-1:0]   uid,
  output logic [3:0]               uid_len,
  output logic [7:0]               sak
);
  localparam logic [1:0] LAST_LEVEL = 2'(MAX_LEVEL);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} fsm_e;

  fsm_e                    state;
  logic [1:0]              level_q;
  logic [KNOWN_W-1:0]      known_q;
  logic [8*DATA_BYTES-1:0] dat_q;
  logic [8*UID_BYTES-1:0]  uid_q;
  logic [3:0]              uid_len_q;
  logic [7:0]              sak_q;
  sel_status_e             status_q;
  logic                    done_q;

  // Frame assembly from current level state
  logic is_select;
  csel_frame_build u_build (
    .level     (level_q),
    .known     (known_q),
    .dat       (dat_q),
    .frame     (txn_frame),
    .len       (txn_len),
    .last_bits (txn_last_bits),
    .is_select (is_select)
  );
  assign txn_rx_align = txn_last_bits;
  assign txn_req      = (state == S_SEND);

  // Acknowledge CRC check
  logic ack_crc_ok;
  csel_ack_check u_ack (
    .ack    (rsp_data[23:0]),
    .crc_ok (ack_crc_ok)
  );

  // Named internal events
  logic fire, coll_abort, coll_retry, ack_shape_ok, ack_more, uid_tagged;
  logic [KNOWN_W-1:0]      coll_pos_eff;
  logic [8*DATA_BYTES-1:0] dat_merged, dat_coll;
  logic [8*UID_BYTES-1:0]  uid_next;
  logic [7:0]              keep_mask;

  assign fire         = (state == S_WAIT) && rsp_valid;
  assign coll_pos_eff = (rsp_coll_pos == 5'd0) ? KNOWN_W'(LEVEL_BITS) : {1'b0, rsp_coll_pos};
  assign coll_abort   = rsp_coll_invalid || (coll_pos_eff <= known_q);
  assign coll_retry   = fire && (rsp_status == RSP_COLL) && !coll_abort;
  assign ack_shape_ok = (rsp_len == 3'd3) && (rsp_last_bits == 3'd0);
  assign ack_more     = rsp_data[2];
  assign keep_mask    = ~(8'hFF << known_q[2:0]);
  assign uid_tagged   = (dat_q[7:0] == CASCADE_TAG) && (level_q < LAST_LEVEL);

  // Merge received bytes behind the known prefix
  always_comb begin
    logic [7:0] rb;
    int off;
    rb  = '0;
    off = int'(known_q[KNOWN_W-1:3]);
    dat_merged = dat_q;
    for (int j = 0; j < DATA_BYTES; j++) begin
      if (j >= off && (j - off) < int'(rsp_len)) begin
        rb = rsp_data[8*(j-off) +: 8];
        if (j == off) dat_merged[8*j +: 8] = (dat_q[8*j +: 8] & keep_mask) | (rb & ~keep_mask);
        else          dat_merged[8*j +: 8] = rb;
      end
    end
  end

  assign dat_coll = dat_merged | ((8*DATA_BYTES)'(1) << (coll_pos_eff - KNOWN_W'(1)));

  // Identifier bytes contributed by the current level
  always_comb begin
    int base;
    base     = 3 * (int'(level_q) - 1);
    uid_next = uid_q;
    for (int j = 0; j < DATA_BYTES; j++) begin
      if (uid_tagged) begin
        if (j < DATA_BYTES - 1) uid_next[8*(base+j) +: 8] = dat_q[8*(j+1) +: 8];
      end else begin
        uid_next[8*(base+j) +: 8] = dat_q[8*j +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      level_q   <= 2'd1;
      known_q   <= '0;
      dat_q     <= '0;
      uid_q     <= '0;
      uid_len_q <= '0;
      sak_q     <= '0;
      status_q  <= ST_OK;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          level_q <= 2'd1;
          known_q <= '0;
          dat_q   <= '0;
          uid_q   <= '0;
          state   <= S_SEND;
        end
        S_SEND: state <= S_WAIT;
        default: if (rsp_valid) begin
          state <= S_IDLE;
          done_q <= 1'b1;
          case (rsp_status)
            RSP_TIMEOUT: status_q <= ST_TIMEOUT;
            RSP_ERR:     status_q <= ST_PROTO;
            RSP_COLL: begin
              if (coll_abort) status_q <= ST_COLL;
              else begin
                dat_q   <= dat_coll;
                known_q <= coll_pos_eff;
                state   <= S_SEND;
                done_q  <= 1'b0;
              end
            end
            default: begin
              if (!is_select) begin
                dat_q   <= dat_merged;
                known_q <= KNOWN_W'(LEVEL_BITS);
                state   <= S_SEND;
                done_q  <= 1'b0;
              end else if (!ack_shape_ok) begin
                status_q <= ST_PROTO;
              end else if (!ack_crc_ok) begin
                status_q <= ST_CRC;
              end else if (ack_more) begin
                if (level_q == LAST_LEVEL) status_q <= ST_PROTO;
                else begin
                  uid_q   <= uid_next;
                  level_q <= level_q + 2'd1;
                  known_q <= '0;
                  dat_q   <= '0;
                  state   <= S_SEND;
                  done_q  <= 1'b0;
                end
              end else begin
                uid_q     <= uid_next;
                uid_len_q <= {2'd0, level_q} * 4'd3 + 4'd1;
                sak_q     <= rsp_data[7:0];
                status_q  <= ST_OK;
              end
            end
          endcase
        end
      endcase
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = done_q;
  assign status  = status_q;
  assign uid     = uid_q;
  assign uid_len = uid_len_q;
  assign sak     = sak_q;

  // R1: every frame begins with a legal level command
  a_r1_cmd_byte: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |-> (txn_frame[7:0] inside {8'h93, 8'h95, 8'h97}));
  // R2: partial frames align reception with the valid-bit nibble
  a_r2_align: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_frame[15:8] != FULL_NVB) |-> (txn_rx_align == txn_frame[10:8]));
  // R3: full-count frames are 9 whole bytes
  a_r3_select_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_frame[15:8] == FULL_NVB) |-> (txn_len == 4'd9 && txn_last_bits == 3'd0));
  // R4: each collision retry strictly grows the known prefix
  a_r4_progress: assert property (@(posedge clk) disable iff (!rst_n)
    coll_retry |=> (known_q > $past(known_q)) && txn_req);
  // R5: unusable collision ends the run
  a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rsp_status == RSP_COLL && coll_abort) |=> (done && status == ST_COLL));
  // R9: timeout reply ends the run
  a_r9_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rsp_status == RSP_TIMEOUT) |=> (done && status == ST_TIMEOUT));
  // R8: successful result has a legal length and a final acknowledge
  a_r8_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_OK) |-> ((uid_len inside {4'd4, 4'd7, 4'd10}) && !sak[2]));
  // R10: single-cycle done, requests only while busy
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |-> busy);
endmodule

// File: tb/csel_seq_test.sv
`timescale 1ns/1ps
module csel_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        txn_req;
  logic [71:0] txn_frame;
  logic [3:0]  txn_len;
  logic [2:0]  txn_last_bits, txn_rx_align;
  logic        rsp_valid = 1'b0;
  logic [1:0]  rsp_status = '0;
  logic [2:0]  rsp_len = '0, rsp_last_bits = '0;
  logic [31:0] rsp_data = '0;
  logic [4:0]  rsp_coll_pos = '0;
  logic        rsp_coll_invalid = 1'b0;
  logic        busy, done;
  logic [2:0]  status;
  logic [79:0] uid;
  logic [3:0]  uid_len;
  logic [7:0]  sak;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  csel_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .txn_req(txn_req), .txn_frame(txn_frame), .txn_len(txn_len),
    .txn_last_bits(txn_last_bits), .txn_rx_align(txn_rx_align),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_len(rsp_len),
    .rsp_last_bits(rsp_last_bits), .rsp_data(rsp_data),
    .rsp_coll_pos(rsp_coll_pos), .rsp_coll_invalid(rsp_coll_invalid),
    .busy(busy), .done(done), .status(status), .uid(uid),
    .uid_len(uid_len), .sak(sak)
  );

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Byte-wise CRC_A formulation
  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
    logic [7:0] ch;
    ch = b ^ c[7:0];
    ch = ch ^ (ch << 4);
    return (c >> 8) ^ ({8'h0, ch} << 8) ^ ({8'h0, ch} << 3) ^ ({8'h0, ch} >> 4);
  endfunction

  function automatic logic [7:0] cmd_of(input int lvl);
    return 8'h93 + 8'(2 * (lvl - 1));
  endfunction

  // Bytes a card returns at level lvl of an n-level identifier
  function automatic logic [31:0] part(input int n, input int lvl, input logic [79:0] id);
    int b;
    b = 3 * (lvl - 1);
    if (n == 1) return id[31:0];
    if (lvl < n) return {id[8*b +: 24], 8'h88};
    return id[8*b +: 32];
  endfunction

  task automatic wait_req(input string tag);
    int n;
    n = 0;
    while (!txn_req && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(tag, {79'd0, txn_req}, 80'd1);
  endtask

  task automatic start_run();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic respond(input logic [1:0] st, input logic [2:0] len, input logic [2:0] lb,
                         input logic [31:0] d, input logic [4:0] pos, input logic inv);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_status = st; rsp_len = len; rsp_last_bits = lb;
    rsp_data = d; rsp_coll_pos = pos; rsp_coll_invalid = inv;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic exp_anti(input string tag, input int lvl, input logic [7:0] nvb,
                          input int len, input logic [2:0] lb, input logic [31:0] d);
    logic [71:0] e, m;
    e = {8'h0, 16'h0, d, nvb, cmd_of(lvl)};
    m = (72'h1 << (8 * len)) - 72'h1;
    chk({tag, " R1 cmd"}, {72'd0, txn_frame[7:0]}, {72'd0, cmd_of(lvl)});
    chk({tag, " R2 frame"}, {8'd0, txn_frame & m}, {8'd0, e & m});
    chk({tag, " R2 len"}, {76'd0, txn_len}, 80'(len));
    chk({tag, " R2 lastbits"}, {77'd0, txn_last_bits}, {77'd0, lb});
    chk({tag, " R2 align"}, {77'd0, txn_rx_align}, {77'd0, lb});
  endtask

  task automatic exp_select(input string tag, input int lvl, input logic [31:0] d);
    logic [71:0] e;
    logic [15:0] c;
    e = '0;
    e[7:0] = cmd_of(lvl);
    e[15:8] = 8'h70;
    e[47:16] = d;
    e[55:48] = d[7:0] ^ d[15:8] ^ d[23:16] ^ d[31:24];
    c = 16'h6363;
    for (int i = 0; i < 7; i++) c = bcrc(c, e[8*i +: 8]);
    e[63:56] = c[7:0];
    e[71:64] = c[15:8];
    chk({tag, " R3 select frame"}, {8'd0, txn_frame}, {8'd0, e});
    chk({tag, " R3 select len"}, {76'd0, txn_len}, 80'd9);
    chk({tag, " R3 select lastbits"}, {77'd0, txn_last_bits}, 80'd0);
  endtask

  task automatic ack_rsp(input logic [7:0] s, input logic bad, input logic [2:0] len);
    logic [15:0] c;
    c = bcrc(16'h6363, s);
    if (bad) c = c ^ 16'h0001;
    respond(2'd0, len, 3'd0, {8'h0, c[15:8], c[7:0], s}, 5'd0, 1'b0);
  endtask

  task automatic level_flow(input string tag, input int lvl, input logic [31:0] d,
                            input logic [7:0] s, input logic bad, input logic [2:0] alen);
    wait_req({tag, " R2 req"});
    exp_anti(tag, lvl, 8'h20, 2, 3'd0, 32'd0);
    respond(2'd0, 3'd4, 3'd0, d, 5'd0, 1'b0);
    wait_req({tag, " R3 req"});
    exp_select(tag, lvl, d);
    ack_rsp(s, bad, alen);
  endtask

  task automatic expect_end(input string tag, input logic [2:0] st);
    chk({tag, " R10 done"}, {79'd0, done}, 80'd1);
    chk({tag, " status"}, {77'd0, status}, {77'd0, st});
    @(negedge clk);
    chk({tag, " R10 done drops"}, {79'd0, done}, 80'd0);
  endtask

  task automatic t_reset();
    chk("R10 reset done", {79'd0, done}, 80'd0);
    chk("R10 reset req", {79'd0, txn_req}, 80'd0);
    chk("R10 reset busy", {79'd0, busy}, 80'd0);
    chk("R10 reset status", {77'd0, status}, 80'd0);
  endtask

  task automatic t_clean(input int n, input logic [79:0] id);
    logic [79:0] m;
    start_run();
    for (int l = 1; l <= n; l++)
      level_flow("clean", l, part(n, l, id), (l < n) ? 8'h04 : 8'h08, 1'b0, 3'd3);
    m = (80'h1 << (8 * (3 * n + 1))) - 80'h1;
    chk("R8 uid", uid, id & m);
    chk("R8 uid_len", {76'd0, uid_len}, 80'(3 * n + 1));
    chk("R8 sak", {72'd0, sak}, 80'h08);
    chk("R7 level count", {79'd0, uid_len == 4'(3 * n + 1)}, 80'd1);
    expect_end("R8 clean", 3'd0);
  endtask

  task automatic t_collision();
    start_run();
    wait_req("R4 req");
    exp_anti("R4 first", 1, 8'h20, 2, 3'd0, 32'd0);
    respond(2'd2, 3'd1, 3'd4, 32'h0000000B, 5'd5, 1'b0);
    wait_req("R4 retry req");
    exp_anti("R4 retry", 1, 8'h25, 3, 3'd5, 32'h0000001B);
    // start while busy must not restart the run (R10)
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    respond(2'd0, 3'd4, 3'd0, 32'h332211C4, 5'd0, 1'b0);
    wait_req("R10 ignored start req");
    exp_select("R4 merged", 1, 32'h332211DB);
    ack_rsp(8'h08, 1'b0, 3'd3);
    chk("R4 uid", uid, 80'h332211DB);
    expect_end("R4 collision", 3'd0);
  endtask

  task automatic t_coll_pos0();
    start_run();
    wait_req("R4 pos0 req");
    respond(2'd2, 3'd4, 3'd0, 32'h04030201, 5'd0, 1'b0);
    wait_req("R4 pos0 select req");
    exp_select("R4 pos0", 1, 32'h84030201);
    ack_rsp(8'h20, 1'b0, 3'd3);
    chk("R4 pos0 uid", uid, 80'h84030201);
    chk("R8 pos0 sak", {72'd0, sak}, 80'h20);
    expect_end("R4 pos0", 3'd0);
  endtask

  task automatic t_abort();
    start_run();
    wait_req("R5 req");
    respond(2'd2, 3'd1, 3'd4, 32'h0B, 5'd5, 1'b1);
    expect_end("R5 invalid", 3'd2);
    start_run();
    wait_req("R5 req2");
    respond(2'd2, 3'd1, 3'd4, 32'h0B, 5'd5, 1'b0);
    wait_req("R5 retry req");
    respond(2'd2, 3'd1, 3'd0, 32'h0, 5'd3, 1'b0);
    expect_end("R5 no progress", 3'd2);
  endtask

  task automatic t_port_fail();
    start_run();
    wait_req("R9 req");
    respond(2'd1, 3'd0, 3'd0, 32'h0, 5'd0, 1'b0);
    expect_end("R9 timeout", 3'd1);
    start_run();
    wait_req("R9 req2");
    respond(2'd3, 3'd0, 3'd0, 32'h0, 5'd0, 1'b0);
    expect_end("R9 error", 3'd4);
  endtask

  task automatic t_bad_ack();
    start_run();
    level_flow("R6 crc", 1, 32'h44332211, 8'h08, 1'b1, 3'd3);
    expect_end("R6 bad crc", 3'd3);
    start_run();
    level_flow("R6 len", 1, 32'h44332211, 8'h08, 1'b0, 3'd2);
    expect_end("R6 short ack", 3'd4);
  endtask

  task automatic t_level3_more();
    logic [79:0] id;
    id = 80'h0A090807060504030201;
    start_run();
    for (int l = 1; l <= 3; l++)
      level_flow("R7 l3", l, part(3, l, id), 8'h04, 1'b0, 3'd3);
    expect_end("R7 level3 cascade", 3'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean(1, 80'h0000000000004D3C2B1A);
    t_clean(2, 80'h00000077665544332211);
    t_clean(3, 80'hA9B8C7D6E5F413243546);
    t_collision();
    t_coll_pos0();
    t_abort();
    t_port_fail();
    t_bad_ack();
    t_level3_more();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule